// File: doc/BRIEF.md
# Sub-Word Store Merge Unit

This block sits between a load/store pipeline and a single-ported local data SRAM. It accepts one request at a time. Each request carries a byte address, an access size, a write flag and store data. It turns each request into SRAM cycles. Loads and full-word stores go straight to the SRAM in the cycle they are presented. The handling of byte and halfword stores depends on the elaboration parameter `BYTE_GRAN`.

With `BYTE_GRAN = 1` the SRAM is assumed to support per-byte writes. Every store then finishes in one cycle, with byte enables covering only the addressed lanes. With `BYTE_GRAN = 0` the SRAM takes only whole 32-bit writes. A sub-word store then becomes a two-cycle read-modify-write, sequenced by a two-state controller:

- **`ST_ACCEPT`** is the reset and idle state.
  - **Transition `T_START_RMW`**: a valid, aligned sub-word store while in `ST_ACCEPT` issues an SRAM read, holds `req_ready` low and moves to `ST_WRITEBACK`.
  - **Transition `T_PASS`**: any other request, or no request, leaves the controller in `ST_ACCEPT`.
- **`ST_WRITEBACK`** writes the merged word and raises `req_ready`.
  - **Transition `T_FINISH`**: the controller returns unconditionally to `ST_ACCEPT`.

The merged word is the word just read, with the store bytes inserted. A requester stalled by a low `req_ready` keeps its request unchanged. A load that follows is therefore only presented after the write-back has been accepted, and it observes the merged word.

The SRAM has a synchronous read: data addressed in cycle N appears on `mem_rdata` in cycle N+1. That data is forwarded unchanged on `req_rdata`.

Top module: `store_merge_unit`

## Requirements
- R1: After reset `req_ready` is high, and while `req_valid` is low `mem_en` stays low.
- R2: A load is accepted in the cycle it is presented. It drives `mem_en=1` and `mem_wen=0` at word address `req_addr[ADDR_W-1:2]`, and the addressed word appears on `req_rdata` one cycle later.
- R3: A full-word store (`req_size` = 2'b10 or 2'b11) completes in one cycle in both modes, with `mem_be` = 4'b1111 and `mem_wdata` = `req_wdata`.
- R4: With `BYTE_GRAN=1`, a byte store (`req_size`=2'b00) or a halfword store (`req_size`=2'b01) completes in one cycle. A byte store sets `mem_be = 4'b0001 << req_addr[1:0]`; a halfword store sets `mem_be = 4'b0011 << req_addr[1:0]`.
- R5: With `BYTE_GRAN=0`, an aligned sub-word store first spends one cycle with `req_ready` low and an SRAM read (`mem_wen=0`). In the next cycle it writes the full word (`mem_be=4'b1111`) with `req_ready` high. Every SRAM write in this mode has all four enables set.
- R6: Byte lanes are little-endian: lane k is `mem_wdata[8k+7:8k]`. Store byte j of `req_wdata` lands in lane `req_addr[1:0]+j`. All other lanes keep their previous contents.
- R7: A halfword store with `req_addr[0]=1` raises `req_err` in the same cycle with `req_ready` high, and causes no SRAM access; memory is left unchanged.
- R8: A load presented directly after a read-modify-write is served only after the write-back, and returns the merged word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 1x word |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| req_ready | output | 1 | Request accepted this cycle |
| req_err | output | 1 | Misaligned halfword store |
| req_rdata | output | 32 | Load data, one cycle after acceptance |
| mem_en | output | 1 | SRAM access enable |
| mem_wen | output | 1 | SRAM write (1) or read (0) |
| mem_addr | output | ADDR_W-2 | SRAM word address |
| mem_be | output | 4 | SRAM byte write enables |
| mem_wdata | output | 32 | SRAM write data |
| mem_rdata | input | 32 | SRAM read data |

## Verification
Suppose the controller were left in `ST_WRITEBACK` wrongly, or missed `T_START_RMW`. The first symptom appears at the ports within one cycle: `req_ready` takes the wrong level, or a write lands during what should be the read cycle. If the lane decode or the merge picks the wrong lane, nothing shows at the handshake. The corrupted word only becomes visible on `req_rdata` one cycle after the next load to that word is accepted. For that reason the stimulus follows sub-word stores with loads, both back-to-back and later in a randomized stream.

// File: rtl/smu_pkg.sv
package smu_pkg;
    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;

    typedef enum logic {
        ST_ACCEPT    = 1'b0,
        ST_WRITEBACK = 1'b1
    } smu_state_e;
endpackage

// File: rtl/smu_lane_decode.sv
module smu_lane_decode
    import smu_pkg::*;
#(
    parameter int LANES = 4,
    localparam int OFF_W = $clog2(LANES),
    localparam int DW    = 8 * LANES
) (
    input  logic [1:0]       size,
    input  logic [OFF_W-1:0] offset,
    input  logic [DW-1:0]    wdata,
    output logic [LANES-1:0] lane_mask,
    output logic [DW-1:0]    lane_data
);
    // Mask of lanes written by the access
    always_comb begin
        unique case (size)
            SZ_BYTE: lane_mask = LANES'(1) << offset;
            SZ_HALF: lane_mask = LANES'(3) << offset;
            default: lane_mask = '1;
        endcase
    end

    // Replicate store bytes so that each lane carries its own byte
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        always_comb begin
            unique case (size)
                SZ_BYTE: lane_data[8*k +: 8] = wdata[7:0];
                SZ_HALF: lane_data[8*k +: 8] = wdata[8*(k % 2) +: 8];
                default: lane_data[8*k +: 8] = wdata[8*k +: 8];
            endcase
        end
    end
endmodule

// File: rtl/smu_merge.sv
module smu_merge #(
    parameter int LANES = 4,
    localparam int DW = 8 * LANES
) (
    input  logic [LANES-1:0] lane_mask,
    input  logic [DW-1:0]    old_word,
    input  logic [DW-1:0]    new_lanes,
    output logic [DW-1:0]    merged
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign merged[8*k +: 8] = lane_mask[k] ? new_lanes[8*k +: 8]
                                               : old_word[8*k +: 8];
    end
endmodule

// File: rtl/smu_ctrl.sv
module smu_ctrl
    import smu_pkg::*;
#(
    parameter bit BYTE_GRAN = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic subword_store,
    output logic rmw_read,
    output logic rmw_write,
    output logic ready
);
    smu_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ACCEPT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        rmw_read  = 1'b0;
        rmw_write = 1'b0;
        ready     = 1'b1;
        unique case (state_q)
            ST_ACCEPT: begin
                if (subword_store && !BYTE_GRAN) begin
                    rmw_read = 1'b1;
                    ready    = 1'b0;
                    state_d  = ST_WRITEBACK;
                end
            end
            ST_WRITEBACK: begin
                rmw_write = 1'b1;
                state_d   = ST_ACCEPT;
            end
        endcase
    end
endmodule

// File: rtl/store_merge_unit.sv
module store_merge_unit
    import smu_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter bit BYTE_GRAN = 1'b0,
    localparam int LANES    = 4,
    localparam int DW       = 8 * LANES,
    localparam int OFF_W    = $clog2(LANES),
    localparam int WA_W     = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic              req_ready,
    output logic              req_err,
    output logic [DW-1:0]     req_rdata,
    output logic              mem_en,
    output logic              mem_wen,
    output logic [WA_W-1:0]   mem_addr,
    output logic [LANES-1:0]  mem_be,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata
);
    logic             misaligned;
    logic             subword;
    logic             rmw_read;
    logic             rmw_write;
    logic [LANES-1:0] lane_mask;
    logic [DW-1:0]    lane_data;

    assign misaligned = (req_size == SZ_HALF) && req_addr[0];
    assign subword    = !req_size[1];
    assign req_err    = req_valid && req_write && misaligned;

    smu_lane_decode #(.LANES(LANES)) u_decode (
        .size      (req_size),
        .offset    (req_addr[OFF_W-1:0]),
        .wdata     (req_wdata),
        .lane_mask (lane_mask),
        .lane_data (lane_data)
    );

    smu_ctrl #(.BYTE_GRAN(BYTE_GRAN)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .subword_store (req_valid && req_write && subword && !misaligned),
        .rmw_read      (rmw_read),
        .rmw_write     (rmw_write),
        .ready         (req_ready)
    );

    assign mem_addr  = req_addr[ADDR_W-1:OFF_W];
    assign mem_en    = req_valid && !req_err;
    assign mem_wen   = mem_en && req_write && !rmw_read;
    assign req_rdata = mem_rdata;

    if (BYTE_GRAN) begin : g_byte_mode
        assign mem_be    = mem_wen ? lane_mask : '0;
        assign mem_wdata = lane_data;
    end else begin : g_word_mode
        logic [DW-1:0] merged;
        smu_merge #(.LANES(LANES)) u_merge (
            .lane_mask (lane_mask),
            .old_word  (mem_rdata),
            .new_lanes (lane_data),
            .merged    (merged)
        );
        assign mem_be    = mem_wen ? '1 : '0;
        assign mem_wdata = rmw_write ? merged : lane_data;
    end
endmodule

// File: rtl/smu_checker.sv
module smu_checker #(
    parameter int ADDR_W    = 12,
    parameter bit BYTE_GRAN = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [1:0]        req_size,
    input logic              req_ready,
    input logic              req_err,
    input logic              mem_en,
    input logic              mem_wen,
    input logic [ADDR_W-3:0] mem_addr,
    input logic [3:0]        mem_be
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !mem_en);

    p_load_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |-> (req_ready && mem_en && !mem_wen));

    p_word_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_size[1]) |-> (req_ready && mem_wen && mem_be == 4'hF));

    p_err_no_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (!mem_en && req_ready));

    if (BYTE_GRAN) begin : g_byte
        p_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && req_write && !req_err) |-> (req_ready && mem_wen));
    end else begin : g_word
        p_full_be_r5: assert property (@(posedge clk) disable iff (!rst_n)
            mem_wen |-> (mem_be == 4'hF));
        p_stall_reads_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && !req_ready) |-> (mem_en && !mem_wen));
        p_stall_then_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && !req_ready) |=> (req_ready && mem_wen && $stable(mem_addr)));
    end
endmodule

bind store_merge_unit smu_checker #(.ADDR_W(ADDR_W), .BYTE_GRAN(BYTE_GRAN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_size  (req_size),
    .req_ready (req_ready),
    .req_err   (req_err),
    .mem_en    (mem_en),
    .mem_wen   (mem_wen),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be)
);

// File: tb/store_merge_unit_tb.sv
`timescale 1ns/1ps
module store_merge_unit_tb;
    localparam int AW = 8;
    localparam int WORDS = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'b10;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        done_w = 1'b0, done_b = 1'b0;
    logic        v_w, v_b;
    assign v_w = req_valid && !done_w;
    assign v_b = req_valid && !done_b;

    logic        rdy_w, err_w, en_w, wen_w, rdy_b, err_b, en_b, wen_b;
    logic [31:0] rdata_w, wd_w, mrd_w, rdata_b, wd_b, mrd_b;
    logic [5:0]  ma_w, ma_b;
    logic [3:0]  be_w, be_b;

    store_merge_unit #(.ADDR_W(AW), .BYTE_GRAN(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(v_w), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(rdy_w), .req_err(err_w), .req_rdata(rdata_w),
        .mem_en(en_w), .mem_wen(wen_w), .mem_addr(ma_w), .mem_be(be_w),
        .mem_wdata(wd_w), .mem_rdata(mrd_w));

    store_merge_unit #(.ADDR_W(AW), .BYTE_GRAN(1'b1)) u_dut_byte (
        .clk(clk), .rst_n(rst_n), .req_valid(v_b), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(rdy_b), .req_err(err_b), .req_rdata(rdata_b),
        .mem_en(en_b), .mem_wen(wen_b), .mem_addr(ma_b), .mem_be(be_b),
        .mem_wdata(wd_b), .mem_rdata(mrd_b));

    int checks = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] init_word(input int i);
        return (32'(i) * 32'h0101_0101) ^ 32'hA5C3_0000;
    endfunction

    // Behavioural request view
    logic mis, sub;
    assign mis = (req_size == 2'b01) && req_addr[0];
    assign sub = !req_size[1];

    function automatic logic [3:0] exp_mask();
        if (req_size == 2'b00) return 4'b0001 << req_addr[1:0];
        if (req_size == 2'b01) return 4'b0011 << req_addr[1:0];
        return 4'b1111;
    endfunction

    function automatic logic [31:0] exp_shifted();
        if (req_size == 2'b00) return (req_wdata & 32'hFF) << (8 * req_addr[1:0]);
        if (req_size == 2'b01) return (req_wdata & 32'hFFFF) << (8 * req_addr[1:0]);
        return req_wdata;
    endfunction

    // SRAM models, ideal shadows, load expectations
    logic [31:0] ram_w [WORDS];
    logic [31:0] ram_b [WORDS];
    logic [31:0] sh_w [WORDS];
    logic [31:0] sh_b [WORDS];
    logic [31:0] exp_w, exp_b;
    logic        pend_w, pend_b, inrmw_w;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                ram_w[i] <= init_word(i);
                ram_b[i] <= init_word(i);
                sh_w[i]  <= init_word(i);
                sh_b[i]  <= init_word(i);
            end
            pend_w <= 1'b0; pend_b <= 1'b0; inrmw_w <= 1'b0;
        end else begin
            if (en_w) begin
                if (wen_w) begin
                    for (int k = 0; k < 4; k++) if (be_w[k]) ram_w[ma_w][8*k +: 8] <= wd_w[8*k +: 8];
                end else mrd_w <= ram_w[ma_w];
            end
            if (en_b) begin
                if (wen_b) begin
                    for (int k = 0; k < 4; k++) if (be_b[k]) ram_b[ma_b][8*k +: 8] <= wd_b[8*k +: 8];
                end else mrd_b <= ram_b[ma_b];
            end
            if (v_w && rdy_w && req_write && !mis)
                for (int k = 0; k < 4; k++)
                    if (exp_mask()[k]) sh_w[req_addr[7:2]][8*k +: 8] <= exp_shifted()[8*k +: 8];
            if (v_b && rdy_b && req_write && !mis)
                for (int k = 0; k < 4; k++)
                    if (exp_mask()[k]) sh_b[req_addr[7:2]][8*k +: 8] <= exp_shifted()[8*k +: 8];
            pend_w <= v_w && rdy_w && !req_write;
            pend_b <= v_b && rdy_b && !req_write;
            if (v_w && rdy_w && !req_write) exp_w <= sh_w[req_addr[7:2]];
            if (v_b && rdy_b && !req_write) exp_b <= sh_b[req_addr[7:2]];
            if (v_w && !rdy_w) inrmw_w <= 1'b1;
            else if (v_w && rdy_w) inrmw_w <= 1'b0;
        end
    end

    // Comparison on every clock, away from the active edge
    always @(negedge clk) begin
        logic exp_rdy_w;
        exp_rdy_w = !(v_w && req_write && sub && !mis && !inrmw_w);
        chk(rdy_w == exp_rdy_w, "R5 word-mode ready", 32'(rdy_w), 32'(exp_rdy_w));
        chk(rdy_b == 1'b1, "R4 byte-mode ready", 32'(rdy_b), 32'd1);
        chk(err_w == (v_w && req_write && mis), "R7 err word", 32'(err_w), 32'(v_w && req_write && mis));
        chk(err_b == (v_b && req_write && mis), "R7 err byte", 32'(err_b), 32'(v_b && req_write && mis));
        if (!v_w) chk(!en_w, "R1 idle word", 32'(en_w), 32'd0);
        if (!v_b) chk(!en_b, "R1 idle byte", 32'(en_b), 32'd0);
        if (req_write && mis) begin
            if (v_w) chk(!en_w, "R7 no access word", 32'(en_w), 32'd0);
            if (v_b) chk(!en_b, "R7 no access byte", 32'(en_b), 32'd0);
        end
        if (v_b && req_write && !mis) begin
            chk(wen_b && be_b == exp_mask(), "R4 R6 byte enables", {27'd0, wen_b, be_b}, {27'd1, exp_mask()});
            for (int k = 0; k < 4; k++)
                if (exp_mask()[k])
                    chk(wd_b[8*k +: 8] == exp_shifted()[8*k +: 8], "R6 lane data", wd_b, exp_shifted());
        end
        if (v_w && req_write && !sub)
            chk(wen_w && be_w == 4'hF && wd_w == req_wdata, "R3 word store", wd_w, req_wdata);
        if (wen_w) chk(be_w == 4'hF, "R5 full enables", 32'(be_w), 32'hF);
        if (v_w && !req_write)
            chk(en_w && !wen_w && ma_w == req_addr[7:2], "R2 load address", 32'(ma_w), 32'(req_addr[7:2]));
        if (pend_w) chk(rdata_w == exp_w, "R2 R6 R8 load data word", rdata_w, exp_w);
        if (pend_b) chk(rdata_b == exp_b, "R2 R6 load data byte", rdata_b, exp_b);
    end

    // Drive one request to both instances; entered and left at posedge + 1
    task automatic do_op(input logic wr, input logic [1:0] sz, input logic [7:0] a, input logic [31:0] d);
        logic acc_w, acc_b;
        req_write = wr; req_size = sz; req_addr = a; req_wdata = d;
        done_w = 1'b0; done_b = 1'b0; req_valid = 1'b1;
        while (!(done_w && done_b)) begin
            @(negedge clk);
            acc_w = v_w && rdy_w;
            acc_b = v_b && rdy_b;
            @(posedge clk); #1;
            if (acc_w) done_w = 1'b1;
            if (acc_b) done_b = 1'b1;
        end
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        req_valid = 1'b0;
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset-state ready
        chk(rdy_w && rdy_b, "R1 reset ready", 32'(rdy_w && rdy_b), 32'd1);
        rst_n = 1'b1;
        idle(2);
        do_op(1'b0, 2'b10, 8'h10, '0);                 // R2 plain load
        do_op(1'b1, 2'b10, 8'h10, 32'h1122_3344);      // R3 word store
        do_op(1'b0, 2'b10, 8'h10, '0);
        for (int j = 0; j < 4; j++)                    // R4 R5 R6 each byte lane
            do_op(1'b1, 2'b00, 8'(8'h20 + j), 32'(8'h90 + j));
        do_op(1'b0, 2'b11, 8'h20, '0);
        do_op(1'b1, 2'b01, 8'h30, 32'hBEEF);           // halfwords, both lanes
        do_op(1'b1, 2'b01, 8'h32, 32'hCAFE);
        do_op(1'b0, 2'b10, 8'h30, '0);
        do_op(1'b1, 2'b01, 8'h41, 32'hDEAD);           // R7 misaligned
        do_op(1'b1, 2'b01, 8'h43, 32'hDEAD);
        do_op(1'b0, 2'b10, 8'h40, '0);                 // R7 memory unchanged
        do_op(1'b1, 2'b00, 8'h57, 32'h77);             // R8 load right after RMW
        do_op(1'b0, 2'b10, 8'h54, '0);
        idle(1);
        for (int n = 0; n < 400; n++)
            do_op(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
                  8'($urandom_range(0, 255)), $urandom());
        for (int w = 0; w < WORDS; w++)
            do_op(1'b0, 2'b10, 8'(w * 4), '0);
        idle(3);
        summary();
    end
endmodule